// File: doc/BRIEF.md
# Table-Driven Partial Quotient Predictor

This stage produces a first estimate of the quotient of two normalized single-precision operands. It takes the biased exponent and the 23-bit fraction of a dividend and of a divisor and returns a predicted partial quotient in single-precision form: a biased exponent and a 23-bit fraction. An iterative divider can then multiply the divisor by this estimate, subtract, and repeat on the remainder.

The leading fraction bits of both operands form the address of a small table. The hidden leading one is not part of the address. Each table word is 8 bits: one exponent-extension bit and a 7-bit mantissa. The mantissa is padded with zeros to fill the fraction. The exponent is the operand exponent difference, with the bias added back, corrected by the extension bit and by an adjust term that is -1 when the dividend significand is smaller than the divisor significand. Every table word is rounded down against the largest divisor its address can stand for, so the estimate never exceeds the true quotient and the next remainder stays non-negative. The table is built at elaboration by a package function. Sign handling, remainder arithmetic and iteration control are outside this block.

A single register stage holds the result. A valid input qualifies each request, and a valid output marks the cycle after it.

Top module: `qp_predict`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `out_exp` and `out_frac` are all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` = 1, and 0 otherwise.
- R3: The table address is {dividend fraction bits [22:23-M], divisor fraction bits [22:23-M]}, with the dividend half in the upper bits (M = 5 by default). Fraction bits below these have no effect on `out_frac`.
- R4: `out_frac[22:16]` holds the 7-bit table mantissa and `out_frac[15:0]` is always zero.
- R5: When the two M-bit address halves differ, let A = 2^M + dividend half and U = 2^M + divisor half + 1. The table mantissa is the first 7 fraction bits of A/U normalized into [1,2), rounded down. If A >= U the value is A/U. Otherwise it is 2A/U.
- R6: When the two address halves are equal, the table mantissa is 0.
- R7: `out_exp` is a 10-bit two's-complement value equal to dividend exponent - divisor exponent + 127 + extension bit + adjust. It does not wrap for any pair of 8-bit exponents. The extension bit is 0 for every table word.
- R8: The adjust term compares the full 23-bit fractions. It is 0 when the dividend fraction is greater than or equal to the divisor fraction, and -1 otherwise.
- R9: The predicted value (1 + mantissa/128) * 2^(out_exp - 127) is no larger than the true quotient of the two operands, and it is more than half of it.
- R10: In a cycle after `in_valid` = 0, `out_exp` and `out_frac` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| in_dvd_exp | input | 8 | Dividend biased exponent |
| in_dvd_frac | input | 23 | Dividend fraction, hidden one omitted |
| in_dvs_exp | input | 8 | Divisor biased exponent |
| in_dvs_frac | input | 23 | Divisor fraction, hidden one omitted |
| out_valid | output | 1 | Result qualifier, one cycle after the request |
| out_exp | output | 10 | Predicted biased exponent, two's complement |
| out_frac | output | 23 | Predicted fraction |

## Verification
Every result (`out_valid`, `out_exp` and `out_frac`) is due one clock edge after the request. There is one register between the ports and the outputs. The bench drives each request on a falling edge, lets one rising edge capture it, and compares all three outputs at the next falling edge. It then drops `in_valid` and checks at the following falling edge that `out_valid` has cleared while the data outputs are unchanged. Expected mantissas come from a bench-side restoring division. Expected exponents come from integer arithmetic on the operands. The lower and upper bounds of R9 are checked against the real quotient.

// File: rtl/qp_pkg.sv
package qp_pkg;

  localparam int FRAC_W = 23;
  localparam int EXP_W  = 8;
  localparam int MANT_W = 7;
  localparam int WORD_W = MANT_W + 1;
  localparam int BIAS   = 127;

  typedef struct packed {
    logic              ext;
    logic [MANT_W-1:0] mant;
  } qp_word_t;

  // Table word for address idx with m bits per operand half.
  // Dividend half in the upper bits. The quotient is rounded down against the
  // divisor's upper bound so the estimate never exceeds the true quotient.
  function automatic qp_word_t qp_entry(input int m, input int idx);
    int a_half;
    int b_half;
    int num;
    int den;
    int q;
    qp_word_t w;
    a_half = idx >> m;
    b_half = idx & ((1 << m) - 1);
    num    = (1 << m) + a_half;
    den    = (1 << m) + b_half + 1;
    w      = '0;
    if (a_half != b_half) begin
      q = (num * 256) / den;
      if (q >= 256) w.mant = MANT_W'((q >> 1) - 128);
      else          w.mant = MANT_W'(q - 128);
      // Set when the table binade disagrees with the one implied by the halves.
      w.ext = ((q >= 256) != (a_half > b_half));
    end
    return w;
  endfunction

endpackage

// File: rtl/qp_addr.sv
module qp_addr #(
  parameter int M      = 5,
  parameter int FRAC_W = 23,
  localparam int ADDR_W = 2 * M
) (
  input  logic [FRAC_W-1:0] dvd_frac,
  input  logic [FRAC_W-1:0] dvs_frac,
  output logic [ADDR_W-1:0] addr,
  output logic              halves_equal,
  output logic              dvd_below
);
  logic [M-1:0] dvd_half;
  logic [M-1:0] dvs_half;

  assign dvd_half     = dvd_frac[FRAC_W-1 -: M];
  assign dvs_half     = dvs_frac[FRAC_W-1 -: M];
  assign addr         = {dvd_half, dvs_half};
  assign halves_equal = (dvd_half == dvs_half);
  // Hidden ones are equal, so comparing the fractions compares the significands.
  assign dvd_below    = (dvd_frac < dvs_frac);
endmodule

// File: rtl/qp_table.sv
module qp_table #(
  parameter int M = 5,
  localparam int ADDR_W = 2 * M,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]  addr,
  output qp_pkg::qp_word_t   word
);
  qp_pkg::qp_word_t tab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign tab[i] = qp_pkg::qp_entry(M, i);
  end

  assign word = tab[addr];
endmodule

// File: rtl/qp_exp.sv
module qp_exp #(
  parameter int EXP_W = 8,
  parameter int BIAS  = 127,
  localparam int OW   = EXP_W + 2
) (
  input  logic [EXP_W-1:0]     dvd_exp,
  input  logic [EXP_W-1:0]     dvs_exp,
  input  logic                 ext,
  input  logic                 dvd_below,
  output logic signed [OW-1:0] q_exp
);
  logic signed [OW-1:0] diff;
  logic signed [OW-1:0] corr;

  always_comb begin
    diff  = $signed({2'b00, dvd_exp}) - $signed({2'b00, dvs_exp});
    corr  = $signed({{(OW-1){1'b0}}, ext}) - $signed({{(OW-1){1'b0}}, dvd_below});
    q_exp = diff + $signed(OW'(BIAS)) + corr;
  end
endmodule

// File: rtl/qp_predict.sv
module qp_predict #(
  parameter int M = 5,
  localparam int FRAC_W = qp_pkg::FRAC_W,
  localparam int EXP_W  = qp_pkg::EXP_W,
  localparam int MANT_W = qp_pkg::MANT_W,
  localparam int OW     = EXP_W + 2,
  localparam int PAD_W  = FRAC_W - MANT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [EXP_W-1:0]  in_dvd_exp,
  input  logic [FRAC_W-1:0] in_dvd_frac,
  input  logic [EXP_W-1:0]  in_dvs_exp,
  input  logic [FRAC_W-1:0] in_dvs_frac,
  output logic              out_valid,
  output logic [OW-1:0]     out_exp,
  output logic [FRAC_W-1:0] out_frac
);
  logic [2*M-1:0]       addr;
  logic                 halves_equal;
  logic                 dvd_below;
  qp_pkg::qp_word_t     word;
  logic signed [OW-1:0] q_exp;
  logic [FRAC_W-1:0]    q_frac;

  qp_addr #(.M(M), .FRAC_W(FRAC_W)) u_addr (
    .dvd_frac     (in_dvd_frac),
    .dvs_frac     (in_dvs_frac),
    .addr         (addr),
    .halves_equal (halves_equal),
    .dvd_below    (dvd_below)
  );

  qp_table #(.M(M)) u_table (
    .addr (addr),
    .word (word)
  );

  qp_exp #(.EXP_W(EXP_W), .BIAS(qp_pkg::BIAS)) u_exp (
    .dvd_exp   (in_dvd_exp),
    .dvs_exp   (in_dvs_exp),
    .ext       (word.ext),
    .dvd_below (dvd_below),
    .q_exp     (q_exp)
  );

  assign q_frac = {word.mant, {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_exp   <= '0;
      out_frac  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_exp  <= q_exp;
        out_frac <= q_frac;
      end
    end
  end

  // R2: result qualifier follows the request by one cycle
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R4: low fraction bits stay zero
  p_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_frac[PAD_W-1:0] == '0));
  // R6: equal halves give a zero mantissa
  p_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && halves_equal) |=> (out_frac == '0));
  // R7: the extension bit is never set for a live request
  p_ext_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !word.ext);
  // R8: a dividend below the divisor lowers the exponent under the bias-corrected difference
  p_adj_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dvd_below) |=>
      ($signed(out_exp) < $signed({2'b00, $past(in_dvd_exp)}) - $signed({2'b00, $past(in_dvs_exp)})
                          + $signed(OW'(qp_pkg::BIAS))));
  // R10: data holds while idle
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_exp) && $stable(out_frac)));
endmodule

// File: tb/qp_predict_tb.sv
`timescale 1ns/1ps
module qp_predict_tb;
  localparam int M = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_dvd_exp = '0;
  logic [22:0] in_dvd_frac = '0;
  logic [7:0]  in_dvs_exp = '0;
  logic [22:0] in_dvs_frac = '0;
  logic        out_valid;
  logic [9:0]  out_exp;
  logic [22:0] out_frac;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qp_predict #(.M(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_dvd_exp(in_dvd_exp), .in_dvd_frac(in_dvd_frac),
    .in_dvs_exp(in_dvs_exp), .in_dvs_frac(in_dvs_frac),
    .out_valid(out_valid), .out_exp(out_exp), .out_frac(out_frac)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Restoring division of the normalized ratio, 7 fraction bits, rounded down.
  function automatic int ref_mant(input int a_half, input int b_half);
    int num;
    int den;
    int rem;
    int m;
    if (a_half == b_half) return 0;
    num = 32 + a_half;
    den = 32 + b_half + 1;
    if (num < den) num = num * 2;
    rem = num - den;
    m = 0;
    for (int k = 0; k < 7; k++) begin
      rem = rem * 2;
      m = m * 2;
      if (rem >= den) begin
        rem = rem - den;
        m = m + 1;
      end
    end
    return m;
  endfunction

  function automatic int ref_exp(input int ea, input int fa, input int eb, input int fb);
    return ea - eb + 127 - ((fa < fb) ? 1 : 0);
  endfunction

  // Drive one request, check its result, then check the idle cycle after it.
  task automatic run(input int ea, input int fa, input int eb, input int fb);
    int em;
    int ee;
    int got_e;
    real pred;
    real truth;
    logic [9:0]  held_e;
    logic [22:0] held_f;
    @(negedge clk);
    in_valid = 1'b1;
    in_dvd_exp = 8'(ea); in_dvd_frac = 23'(fa);
    in_dvs_exp = 8'(eb); in_dvs_frac = 23'(fb);
    @(negedge clk);
    in_valid = 1'b0;
    em = ref_mant(fa >> 18, fb >> 18);
    ee = ref_exp(ea, fa, eb, fb);
    got_e = int'($signed(out_exp));
    chk(out_valid === 1'b1, "R2", longint'(out_valid), 1);
    chk(out_frac[15:0] === 16'd0, "R4", longint'(out_frac[15:0]), 0);
    if ((fa >> 18) == (fb >> 18))
      chk(out_frac[22:16] === 7'd0, "R6", longint'(out_frac[22:16]), 0);
    else
      chk(int'(out_frac[22:16]) == em, "R5", longint'(out_frac[22:16]), em);
    chk(got_e == ee, "R7/R8", got_e, ee);
    pred  = (1.0 + real'(out_frac[22:16]) / 128.0) * (2.0 ** (got_e - 127));
    truth = ((1.0 + real'(fa) / 8388608.0) / (1.0 + real'(fb) / 8388608.0)) * (2.0 ** (ea - eb));
    chk(pred <= truth && pred > truth / 2.0, "R9", longint'(pred * 1.0e6), longint'(truth * 1.0e6));
    held_e = out_exp;
    held_f = out_frac;
    @(negedge clk);
    chk(out_valid === 1'b0, "R2", longint'(out_valid), 0);
    chk(out_exp === held_e && out_frac === held_f, "R10", longint'(out_frac), longint'(held_f));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    chk(out_exp === 10'd0 && out_frac === 23'd0, "R1", longint'(out_frac), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_frac === 23'd0, "R1", longint'(out_valid), 0);
  endtask

  task automatic t_patterns;  // R5 with several distinct halves
    run(130, 23'h7FFFFF, 127, 23'h000000);
    run(127, 23'h000000, 127, 23'h7FFFFF);
    run(140, 23'h400000, 120, 23'h200000);
    run(100, 23'h1C0000, 110, 23'h5A0000);
    run(127, 23'h7C0000, 127, 23'h040000);
  endtask

  task automatic t_equal_halves;  // R6 and R8 across the three fraction orderings
    run(127, 23'h2A0010, 127, 23'h2A0020);
    run(127, 23'h2A0020, 127, 23'h2A0020);
    run(127, 23'h2A0030, 127, 23'h2A0020);
  endtask

  task automatic t_low_bits;  // R3: bits below the address have no effect on the fraction
    logic [22:0] first;
    run(127, 23'h500000, 127, 23'h300000);
    first = out_frac;
    run(127, 23'h53FFFF, 127, 23'h33FFFF);
    chk(out_frac === first, "R3", longint'(out_frac), longint'(first));
    run(127, 23'h500000, 127, 23'h33FFFF);
    chk(out_frac === first, "R3", longint'(out_frac), longint'(first));
  endtask

  task automatic t_exp_range;  // R7 extremes without wrap
    run(1, 23'h000000, 254, 23'h000001);
    run(254, 23'h000001, 1, 23'h000000);
    run(0, 23'h100000, 255, 23'h100000);
  endtask

  task automatic t_sweep;  // R9 over pseudo-random operands
    int s;
    s = 32'h1234567;
    for (int n = 0; n < 150; n++) begin
      int fa;
      int fb;
      int ea;
      int eb;
      s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
      fa = s & 32'h7FFFFF;
      s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
      fb = s & 32'h7FFFFF;
      ea = 100 + (n % 50);
      eb = 90 + (n % 70);
      run(ea, fa, eb, fb);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_patterns;
    t_equal_halves;
    t_low_bits;
    t_exp_range;
    t_sweep;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run;
  end
endmodule